// File: doc/BRIEF.md
# Multi-unit packet sampling mask

This block merges the verdicts of a bank of parallel packet samplers into one per-packet decision. Every packet descriptor carries a control word. One half of it is an assignment mask with one bit per sampling unit, and the other half is carried through untouched. Each unit named in the mask applies its own sampling rule to the packet. The mask is then narrowed to the units that actually passed the packet. A packet that ends up with an all-zero mask is flagged for discard.

Each unit is either off (it passes nothing), set to pass everything, or set to deterministic one-in-n sampling. A unit in one-in-n mode counts only the packets assigned to it. A host side programs the units through two write strobes: a mode strobe that addresses one unit by index, and a per-unit reload vector that loads the sampling period. A descriptor is accepted with a valid/ready handshake, and its result appears exactly one cycle later.

Top module: `pkt_sample_mask`

## Requirements
- R1: With default parameters the assignment mask is control-word bits [31:16], with bit 16+u belonging to unit u. The output mask is that input mask ANDed bitwise with the vector of unit pass results.
- R2: One clock after a descriptor is accepted, out_valid is 1 for one cycle and out_keep equals control-word bits [15:0] unchanged.
- R3: out_discard is 1 exactly when the output mask is all zeros.
- R4: Mode codes on cfg_mode are: 0 = off (never passes), 1 = deterministic one-in-n, 2 = pass every assigned packet, 3 = treated as off.
- R5: In mode 1 a unit passes the n-th assigned packet since its last pass or since its last reload, and then starts counting again. When n = 1 it passes every assigned packet, and n = 0 behaves as n = 1.
- R6: A packet whose mask bit for a unit is 0 does not advance that unit's count.
- R7: cfg_mode_wr writes cfg_mode into unit cfg_unit. A set bit u of cfg_init_wr loads cfg_n as unit u's period and restarts its count. If cfg_mode_wr and any cfg_init_wr bit are high in the same cycle, the whole write is ignored.
- R8: in_ready is 0 in any cycle in which a configuration strobe is high. A descriptor offered in that cycle is not taken and produces no output.
- R9: An accepted beat is a descriptor only when in_ctrl_flag = 1 and in_data_flag = 0. Any other beat produces no output and moves no count. in_ctrl_flag and in_data_flag are never both 1 on a valid beat.
- R10: After reset every unit is off with a zero count and out_valid = 0, so any packet is discarded until the units are configured.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| cfg_mode_wr | input | 1 | Mode write strobe |
| cfg_unit | input | 4 | Unit index for a mode write |
| cfg_mode | input | 2 | Mode code to write |
| cfg_init_wr | input | 16 | Per-unit period reload strobes |
| cfg_n | input | 8 | Sampling period to load |
| in_valid | input | 1 | Descriptor or beat offered |
| in_ready | output | 1 | Beat can be taken this cycle |
| in_ctrl | input | 32 | Control word |
| in_ctrl_flag | input | 1 | Beat is a control descriptor |
| in_data_flag | input | 1 | Beat is payload data |
| out_valid | output | 1 | Result valid |
| out_mask | output | 16 | Narrowed assignment mask |
| out_keep | output | 16 | Unchanged other half of the control word |
| out_discard | output | 1 | No unit passed the packet |

## Verification
The bench builds the block with its default parameters: sixteen units, a 32-bit control word with the mask in the upper half, and 8-bit sampling periods. The bench draws periods from 0 to 5. That range makes counter wrap, the n = 0 and n = 1 cases, and several units passing or refusing the same packet all occur within a few hundred descriptors. Conflicting configuration writes, payload beats and descriptors offered during configuration are mixed into the random traffic, so ignored writes and stalled descriptors are seen against live count state.

// File: rtl/psm_pkg.sv
package psm_pkg;
   typedef enum logic [1:0] {
      SMP_OFF = 2'd0,
      SMP_DET = 2'd1,
      SMP_ALL = 2'd2,
      SMP_RSV = 2'd3
   } smp_mode_e;
endpackage

// File: rtl/psm_cfg_guard.sv
// Decodes host configuration strobes into per-unit write enables and
// drops a write whose mode strobe and reload vector collide.
module psm_cfg_guard #(
   parameter int NUM_UNITS = 16,
   parameter int UIDX_W    = 4
) (
   input  logic                 cfg_mode_wr,
   input  logic [UIDX_W-1:0]    cfg_unit,
   input  logic [NUM_UNITS-1:0] cfg_init_wr,
   output logic [NUM_UNITS-1:0] mode_we,
   output logic [NUM_UNITS-1:0] n_we,
   output logic                 busy
);
   logic                 clash;
   logic [NUM_UNITS-1:0] unit_sel;

   for (genvar g = 0; g < NUM_UNITS; g++) begin : g_sel
      assign unit_sel[g] = (cfg_unit == UIDX_W'(g));
   end

   assign clash   = cfg_mode_wr & (|cfg_init_wr);
   assign busy    = cfg_mode_wr | (|cfg_init_wr);
   assign mode_we = (cfg_mode_wr & ~clash) ? unit_sel : '0;
   assign n_we    = clash ? '0 : cfg_init_wr;
endmodule

// File: rtl/psm_unit.sv
// One sampling unit: holds its mode, period and count of assigned packets.
module psm_unit
   import psm_pkg::*;
#(
   parameter int CNT_W = 8
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             mode_we,
   input  logic             n_we,
   input  smp_mode_e        mode_in,
   input  logic [CNT_W-1:0] n_in,
   input  logic             take,
   output logic             pass
);
   smp_mode_e        mode_q;
   logic [CNT_W-1:0] n_q;
   logic [CNT_W-1:0] cnt_q;
   logic [CNT_W:0]   cnt_nx;
   logic [CNT_W:0]   n_eff;
   logic             hit;

   assign n_eff  = (n_q == '0) ? (CNT_W+1)'(1) : {1'b0, n_q};
   assign cnt_nx = {1'b0, cnt_q} + (CNT_W+1)'(1);
   assign hit    = (cnt_nx >= n_eff);

   always_comb begin
      unique case (mode_q)
         SMP_DET: pass = hit;
         SMP_ALL: pass = 1'b1;
         default: pass = 1'b0;
      endcase
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         mode_q <= SMP_OFF;
         n_q    <= CNT_W'(1);
         cnt_q  <= '0;
      end else begin
         if (mode_we) mode_q <= mode_in;
         if (n_we) begin
            n_q   <= n_in;
            cnt_q <= '0;
         end else if (take && mode_q == SMP_DET) begin
            cnt_q <= hit ? '0 : cnt_nx[CNT_W-1:0];
         end
      end
   end

   AST_WR_EXCL: assert property (@(posedge clk) disable iff (!rst_n)
      !(mode_we && n_we)); // R7
   AST_CNT_BOUND: assert property (@(posedge clk) disable iff (!rst_n)
      ({1'b0, cnt_q} < ((n_q == '0) ? (CNT_W+1)'(1) : {1'b0, n_q}))); // R5
   AST_IDLE_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
      (!take && !n_we) |=> $stable(cnt_q)); // R6
   AST_DET_WRAP: assert property (@(posedge clk) disable iff (!rst_n)
      (take && mode_q == SMP_DET && pass && !n_we) |=> (cnt_q == '0)); // R5
endmodule

// File: rtl/pkt_sample_mask.sv
module pkt_sample_mask
   import psm_pkg::*;
#(
   parameter int NUM_UNITS     = 16,
   parameter int CTRL_W        = 32,
   parameter int CNT_W         = 8,
   parameter bit MASK_IN_UPPER = 1'b1
) (
   input  logic                          clk,
   input  logic                          rst_n,
   input  logic                          cfg_mode_wr,
   input  logic [$clog2(NUM_UNITS)-1:0]  cfg_unit,
   input  logic [1:0]                    cfg_mode,
   input  logic [NUM_UNITS-1:0]          cfg_init_wr,
   input  logic [CNT_W-1:0]              cfg_n,
   input  logic                          in_valid,
   output logic                          in_ready,
   input  logic [CTRL_W-1:0]             in_ctrl,
   input  logic                          in_ctrl_flag,
   input  logic                          in_data_flag,
   output logic                          out_valid,
   output logic [NUM_UNITS-1:0]          out_mask,
   output logic [CTRL_W/2-1:0]           out_keep,
   output logic                          out_discard
);
   localparam int HALF   = CTRL_W / 2;
   localparam int UIDX_W = $clog2(NUM_UNITS);

   if (CTRL_W != 2 * NUM_UNITS) begin : g_bad_width
      $error("control word must be twice the unit count");
   end
   if (NUM_UNITS < 2) begin : g_bad_units
      $error("at least two sampling units are required");
   end
   if (CNT_W < 1) begin : g_bad_cnt
      $error("period width must be at least one bit");
   end

   logic [NUM_UNITS-1:0] mask_in;
   logic [HALF-1:0]      keep_in;
   logic [NUM_UNITS-1:0] mode_we;
   logic [NUM_UNITS-1:0] n_we;
   logic [NUM_UNITS-1:0] pass_v;
   logic [NUM_UNITS-1:0] kept;
   logic                 cfg_busy;
   logic                 desc;

   if (MASK_IN_UPPER) begin : g_mask_hi
      assign mask_in = in_ctrl[CTRL_W-1:HALF];
      assign keep_in = in_ctrl[HALF-1:0];
   end else begin : g_mask_lo
      assign mask_in = in_ctrl[HALF-1:0];
      assign keep_in = in_ctrl[CTRL_W-1:HALF];
   end

   psm_cfg_guard #(.NUM_UNITS(NUM_UNITS), .UIDX_W(UIDX_W)) u_guard (
      .cfg_mode_wr (cfg_mode_wr),
      .cfg_unit    (cfg_unit),
      .cfg_init_wr (cfg_init_wr),
      .mode_we     (mode_we),
      .n_we        (n_we),
      .busy        (cfg_busy)
   );

   assign in_ready = ~cfg_busy;
   assign desc     = in_valid & in_ready & in_ctrl_flag & ~in_data_flag;

   for (genvar u = 0; u < NUM_UNITS; u++) begin : g_unit
      psm_unit #(.CNT_W(CNT_W)) u_smp (
         .clk     (clk),
         .rst_n   (rst_n),
         .mode_we (mode_we[u]),
         .n_we    (n_we[u]),
         .mode_in (smp_mode_e'(cfg_mode)),
         .n_in    (cfg_n),
         .take    (desc & mask_in[u]),
         .pass    (pass_v[u])
      );
   end

   assign kept = mask_in & pass_v;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         out_valid   <= 1'b0;
         out_mask    <= '0;
         out_keep    <= '0;
         out_discard <= 1'b0;
      end else begin
         out_valid <= desc;
         if (desc) begin
            out_mask    <= kept;
            out_keep    <= keep_in;
            out_discard <= ~(|kept);
         end
      end
   end

   AST_FLAG_EXCL: assert property (@(posedge clk) disable iff (!rst_n)
      !(in_valid && in_ctrl_flag && in_data_flag)); // R9
   AST_ONE_CYCLE: assert property (@(posedge clk) disable iff (!rst_n)
      desc |=> out_valid); // R2
   AST_NO_SPURIOUS: assert property (@(posedge clk) disable iff (!rst_n)
      !(in_valid && in_ctrl_flag && !cfg_mode_wr && cfg_init_wr == '0) |=> !out_valid); // R8
   AST_MASK_SUBSET: assert property (@(posedge clk) disable iff (!rst_n)
      desc |=> ((out_mask & ~$past(mask_in)) == '0)); // R1
   AST_KEEP_HALF: assert property (@(posedge clk) disable iff (!rst_n)
      desc |=> (out_keep == $past(keep_in))); // R2
   AST_DISCARD_EMPTY: assert property (@(posedge clk) disable iff (!rst_n)
      out_valid |-> (out_discard == (out_mask == '0))); // R3
endmodule

// File: tb/pkt_sample_mask_bench.sv
module pkt_sample_mask_bench;
   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic        cfg_mode_wr = 1'b0;
   logic [3:0]  cfg_unit = '0;
   logic [1:0]  cfg_mode = '0;
   logic [15:0] cfg_init_wr = '0;
   logic [7:0]  cfg_n = '0;
   logic        in_valid = 1'b0;
   logic        in_ready;
   logic [31:0] in_ctrl = '0;
   logic        in_ctrl_flag = 1'b0;
   logic        in_data_flag = 1'b0;
   logic        out_valid;
   logic [15:0] out_mask;
   logic [15:0] out_keep;
   logic        out_discard;

   int checks = 0;
   int fails  = 0;

   logic [1:0] mode_m [16];
   logic [7:0] n_m    [16];
   int         cnt_m  [16];

   always #2.5 clk = ~clk;

   pkt_sample_mask u_pkt_sample_mask (
      .clk(clk), .rst_n(rst_n),
      .cfg_mode_wr(cfg_mode_wr), .cfg_unit(cfg_unit), .cfg_mode(cfg_mode),
      .cfg_init_wr(cfg_init_wr), .cfg_n(cfg_n),
      .in_valid(in_valid), .in_ready(in_ready), .in_ctrl(in_ctrl),
      .in_ctrl_flag(in_ctrl_flag), .in_data_flag(in_data_flag),
      .out_valid(out_valid), .out_mask(out_mask), .out_keep(out_keep),
      .out_discard(out_discard)
   );

   task automatic chk(input bit ok, input string req, input string act, input string exp);
      checks++;
      if (!ok) begin
         fails++;
         $display("FAIL %s actual=%s expected=%s", req, act, exp);
      end
   endtask

   function automatic bit model_pass(input int u);
      int neff;
      neff = (n_m[u] == 0) ? 1 : int'(n_m[u]);
      case (mode_m[u])
         2'd1:    return (cnt_m[u] + 1 >= neff);
         2'd2:    return 1'b1;
         default: return 1'b0;
      endcase
   endfunction

   // R1 R3 R5 R6 R9: offer one beat, predict from the model, check next cycle
   task automatic send(input logic [31:0] ctrl, input bit cf, input bit df, input string req);
      logic [15:0] m;
      logic [15:0] exp_mask;
      bit          is_desc;
      m = ctrl[31:16];
      is_desc = cf && !df;
      exp_mask = '0;
      for (int u = 0; u < 16; u++) exp_mask[u] = m[u] & model_pass(u);
      if (is_desc)
         for (int u = 0; u < 16; u++)
            if (m[u] && mode_m[u] == 2'd1)
               cnt_m[u] = model_pass(u) ? 0 : cnt_m[u] + 1;
      @(negedge clk);
      in_valid = 1'b1; in_ctrl = ctrl; in_ctrl_flag = cf; in_data_flag = df;
      @(negedge clk);
      in_valid = 1'b0; in_ctrl_flag = 1'b0; in_data_flag = 1'b0;
      if (is_desc) begin
         chk(out_valid === 1'b1, {req, " R2 valid"}, $sformatf("%b", out_valid), "1");
         chk(out_mask === exp_mask, {req, " R1 mask"},
             $sformatf("%h", out_mask), $sformatf("%h", exp_mask));
         chk(out_keep === ctrl[15:0], {req, " R2 keep"},
             $sformatf("%h", out_keep), $sformatf("%h", ctrl[15:0]));
         chk(out_discard === (exp_mask == 0), {req, " R3 discard"},
             $sformatf("%b", out_discard), $sformatf("%b", exp_mask == 0));
      end else begin
         chk(out_valid === 1'b0, {req, " R9 no output"}, $sformatf("%b", out_valid), "0");
      end
   endtask

   // R7 R8: configuration write with a descriptor offered alongside
   task automatic cfgw(input bit mw, input int unit, input logic [1:0] mode,
                       input logic [15:0] iw, input logic [7:0] n, input string req);
      bit busy;
      busy = mw || (iw != 0);
      @(negedge clk);
      cfg_mode_wr = mw; cfg_unit = 4'(unit); cfg_mode = mode; cfg_init_wr = iw; cfg_n = n;
      in_valid = 1'b1; in_ctrl = 32'hFFFF_1234; in_ctrl_flag = 1'b1;
      #1;
      chk(in_ready === !busy, {req, " R8 ready"}, $sformatf("%b", in_ready), $sformatf("%b", !busy));
      @(negedge clk);
      cfg_mode_wr = 1'b0; cfg_init_wr = '0; in_valid = 1'b0; in_ctrl_flag = 1'b0;
      if (busy)
         chk(out_valid === 1'b0, {req, " R8 stalled"}, $sformatf("%b", out_valid), "0");
      if (!(mw && iw != 0)) begin
         if (mw) mode_m[unit] = mode;
         for (int u = 0; u < 16; u++)
            if (iw[u]) begin n_m[u] = n; cnt_m[u] = 0; end
      end
      if (!busy)
         // a descriptor went through; keep the model in step
         for (int u = 0; u < 16; u++)
            if (mode_m[u] == 2'd1)
               cnt_m[u] = (cnt_m[u] + 1 >= ((n_m[u] == 0) ? 1 : int'(n_m[u]))) ? 0 : cnt_m[u] + 1;
   endtask

   initial begin
      #500us;
      fails++;
      $display("FAIL watchdog expired actual=running expected=finished");
      $display("== %0d vectors applied, %0d miscompares ==", checks, fails);
      $finish;
   end

   initial begin
      for (int u = 0; u < 16; u++) begin mode_m[u] = 2'd0; n_m[u] = 8'd1; cnt_m[u] = 0; end
      repeat (3) @(negedge clk);
      rst_n = 1'b1;
      @(negedge clk);
      chk(out_valid === 1'b0, "R10 out_valid", $sformatf("%b", out_valid), "0");
      chk(in_ready === 1'b1, "R10 in_ready", $sformatf("%b", in_ready), "1");
      send(32'hFFFF_A5A5, 1'b1, 1'b0, "R10 all off");

      cfgw(1'b1, 0, 2'd2, 16'h0000, 8'd0, "R4 unit0 all");
      cfgw(1'b0, 0, 2'd0, 16'h0008, 8'd3, "R5 unit3 n3");
      cfgw(1'b1, 3, 2'd1, 16'h0000, 8'd0, "R5 unit3 det");
      cfgw(1'b0, 0, 2'd0, 16'h00A0, 8'd1, "R5 unit5/7 n");
      cfgw(1'b0, 0, 2'd0, 16'h0080, 8'd0, "R5 unit7 n0");
      cfgw(1'b1, 5, 2'd1, 16'h0000, 8'd0, "R5 unit5 det");
      cfgw(1'b1, 7, 2'd1, 16'h0000, 8'd0, "R5 unit7 det");
      cfgw(1'b1, 9, 2'd3, 16'h0000, 8'd0, "R4 unit9 rsv");
      for (int i = 0; i < 4; i++) send(32'h02A9_0000 | 32'(i), 1'b1, 1'b0, "R5 det sweep");
      for (int i = 0; i < 3; i++) send(32'h0001_FFFF, 1'b1, 1'b0, "R6 unit3 unassigned");
      send(32'h0008_0F0F, 1'b1, 1'b0, "R6 unit3 resume");
      send(32'h0200_0000, 1'b1, 1'b0, "R4 reserved mode");
      cfgw(1'b1, 0, 2'd0, 16'h0008, 8'd1, "R7 clash");
      send(32'h0009_5555, 1'b1, 1'b0, "R7 clash ignored");
      send(32'h0008_0000, 1'b0, 1'b1, "R9 data beat");
      send(32'h0008_0000, 1'b0, 1'b0, "R9 flagless beat");
      send(32'h0008_AAAA, 1'b1, 1'b0, "R9 count unmoved");

      for (int i = 0; i < 400; i++) begin
         int sel;
         sel = $urandom_range(0, 9);
         if (sel == 0)
            cfgw($urandom_range(0, 1) == 1, $urandom_range(0, 15), 2'($urandom_range(0, 3)),
                 ($urandom_range(0, 2) == 0) ? 16'($urandom) : 16'h0,
                 8'($urandom_range(0, 5)), "R7 random cfg");
         else if (sel == 1)
            send($urandom, 1'b0, $urandom_range(0, 1) == 1, "R9 random beat");
         else
            send($urandom, 1'b1, 1'b0, "R1 random pkt");
      end

      $display("== %0d vectors applied, %0d miscompares ==", checks, fails);
      $finish;
   end

   initial begin
      void'($urandom(32'd20240611));
   end
endmodule